// File: doc/BRIEF.md
# Hash Store and Check Unit

This unit executes two return-address protection instructions in the load/store stage of a fixed-point core. Both instructions combine the contents of two source registers with a secret key to form a 64-bit digest. The store form writes the digest to memory. The check form reads 64 bits back from the same kind of address and raises a program trap when the value read differs from the digest.

The unit decodes the instruction word and forms the effective address. The base register value is added to a negative doubleword displacement built from a split 6-bit field. The unit then asks an external hash engine for the digest and issues one 64-bit memory request.

On a core that reports an ISA level older than 3.1, both instructions finish as no-ops. A zero base-register field is an invalid form and is reported as an illegal instruction. Register read, caches and translation belong to the surrounding pipeline.

Top module: `hash_guard_unit`

## Requirements
- R1: An instruction is handled only if bits 31:26 equal 011111 and bits 10:1 equal 1011010010 (store form) or 1011110010 (check form). Any other word presented with `start` is ignored: `busy`, `done`, `illegal`, `hash_req` and `mem_req` all stay low.
- R2: The memory address equals `ra_val` plus a displacement. The displacement has bits 63:9 set, bits 8:3 set to {instr[0], instr[25:21]}, and bits 2:0 clear. This gives −512 to −8 in steps of 8.
- R3: With `isa_v31` high and the base field instr[20:16] equal to zero, `done` and `illegal` pulse together in the cycle after `start`. No hash or memory request is made.
- R4: With `isa_v31` low, a handled instruction pulses `done` alone in the cycle after `start`. No flag is raised and no request is made, whatever the base field holds.
- R5: For a valid form, `hash_req` rises in the cycle after `start`. It carries the values of `ra_val`, `rb_val` and `hkey` captured at `start`, and holds until `hash_ack`.
- R6: The store form next raises `mem_req` with `mem_we` high and `mem_wdata` equal to the returned digest. Address, direction and data hold until `mem_ack`. `done` pulses in the following cycle with `trap` low.
- R7: The check form raises `mem_req` with `mem_we` low. In the cycle after `mem_ack`, `done` pulses, and `trap` pulses with it exactly when `mem_rdata` differs from the digest.
- R8: `busy` is high from the cycle after an accepted valid-form `start` until the cycle in which `done` pulses, where it is low. Each instruction yields a single one-cycle `done`.
- R9: `start` is ignored while `busy` is high.
- R10: After reset, every output flag and request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| isa_v31 | input | 1 | High when the core implements ISA level 3.1 or later |
| ra_val | input | XLEN | Base register contents |
| rb_val | input | XLEN | Second source register contents |
| hkey | input | 64 | Hash key register contents |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Invalid form, pulses with done |
| trap | output | 1 | Digest mismatch, pulses with done |
| hash_req | output | 1 | Digest request to hash engine |
| hash_a | output | XLEN | First digest operand |
| hash_b | output | XLEN | Second digest operand |
| hash_key | output | 64 | Key for the digest |
| hash_ack | input | 1 | Digest valid |
| hash_digest | input | 64 | Digest result |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Effective address |
| mem_wdata | output | 64 | Store data |
| mem_ack | input | 1 | Memory request complete |
| mem_rdata | input | 64 | Load data, valid with mem_ack |

## Verification
The completion pulse of one instruction and the `start` of the next can fall in the same cycle, because `busy` is already low when `done` pulses. The bench issues each new instruction in the very cycle where it checks the previous `done`. Runs of no-op and illegal forms then give back-to-back `done` pulses. Each pulse must match the flags expected for its own instruction. A `start` offered mid-flight is also injected, and the bench judges that it leaves the flags, direction and address of the running instruction untouched.

// File: rtl/hash_guard_unit.sv
module hash_guard_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic            isa_v31,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [63:0]     hkey,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            trap,
  output logic            hash_req,
  output logic [XLEN-1:0] hash_a,
  output logic [XLEN-1:0] hash_b,
  output logic [63:0]     hash_key,
  input  logic            hash_ack,
  input  logic [63:0]     hash_digest,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [63:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [63:0]     mem_rdata
);
  localparam logic [5:0] OPC     = 6'b011111;
  localparam logic [9:0] XO_ST   = 10'b1011010010;
  localparam logic [9:0] XO_CHK  = 10'b1011110010;
  localparam int         DISP_HI = XLEN - 9;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_MEM} state_t;

  state_t          st;
  logic            chk_q;
  logic [XLEN-1:0] ea_q, a_q, b_q;
  logic [63:0]     key_q, dig_q;

  wire             opc_ok  = instr[31:26] == OPC;
  wire             is_st   = opc_ok && instr[10:1] == XO_ST;
  wire             is_chk  = opc_ok && instr[10:1] == XO_CHK;
  wire             is_op   = is_st || is_chk;
  wire [4:0]       ra_fld  = instr[20:16];
  wire [5:0]       dx      = {instr[0], instr[25:21]};
  wire [XLEN-1:0]  disp    = {{DISP_HI{1'b1}}, dx, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      illegal <= 1'b0;
      trap    <= 1'b0;
      chk_q   <= 1'b0;
      ea_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      key_q   <= '0;
      dig_q   <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      trap    <= 1'b0;
      unique case (st)
        S_IDLE: if (start && is_op) begin
          if (!isa_v31) begin
            done <= 1'b1;
          end else if (ra_fld == 5'd0) begin
            done    <= 1'b1;
            illegal <= 1'b1;
          end else begin
            st    <= S_HASH;
            chk_q <= is_chk;
            ea_q  <= ra_val + disp;
            a_q   <= ra_val;
            b_q   <= rb_val;
            key_q <= hkey;
          end
        end
        S_HASH: if (hash_ack) begin
          dig_q <= hash_digest;
          st    <= S_MEM;
        end
        S_MEM: if (mem_ack) begin
          done <= 1'b1;
          trap <= chk_q && (mem_rdata != dig_q);
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign hash_req  = st == S_HASH;
  assign hash_a    = a_q;
  assign hash_b    = b_q;
  assign hash_key  = key_q;
  assign mem_req   = st == S_MEM;
  assign mem_we    = (st == S_MEM) && !chk_q;
  assign mem_addr  = ea_q;
  assign mem_wdata = dig_q;
endmodule

// File: rtl/hash_guard_chk.sv
module hash_guard_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            illegal,
  input logic            trap,
  input logic            hash_req,
  input logic            hash_ack,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr
);
  p_illegal_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);
  p_trap_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done && !illegal);
  p_hash_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hash_req && !hash_ack |=> hash_req);
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_mem_after_hash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(hash_req && hash_ack));
  p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_req || mem_req) |-> busy);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_one_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hash_req && mem_req));
endmodule

bind hash_guard_unit hash_guard_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .trap(trap), .hash_req(hash_req), .hash_ack(hash_ack), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/hash_guard_unit_tb.sv
module hash_guard_unit_tb;
  logic        clk = 0, rst_n = 0, start = 0, isa_v31 = 1;
  logic [31:0] instr = '0;
  logic [63:0] ra_val = '0, rb_val = '0, hkey = '0;
  logic        busy, done, illegal, trap, hash_req, mem_req, mem_we;
  logic [63:0] hash_a, hash_b, hash_key, mem_addr, mem_wdata;
  logic        hash_ack = 0, mem_ack = 0;
  logic [63:0] hash_digest = '0, mem_rdata = '0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  hash_guard_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .isa_v31(isa_v31),
    .ra_val(ra_val), .rb_val(rb_val), .hkey(hkey), .busy(busy), .done(done),
    .illegal(illegal), .trap(trap), .hash_req(hash_req), .hash_a(hash_a),
    .hash_b(hash_b), .hash_key(hash_key), .hash_ack(hash_ack),
    .hash_digest(hash_digest), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input bit c, input logic [4:0] ra, input logic [4:0] rb, input logic [5:0] dx);
    return {6'b011111, dx[4:0], ra, rb, c ? 10'b1011110010 : 10'b1011010010, dx[5]};
  endfunction

  function automatic logic [63:0] exp_ea(input logic [31:0] w, input logic [63:0] base);
    logic [63:0] d = 64'hFFFF_FFFF_FFFF_FE00;
    d[8:3] = {w[0], w[25:21]};
    return base + d;
  endfunction

  task automatic run(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                     input logic [63:0] k, input bit v31, input int hl, input int ml,
                     input logic [63:0] dig, input logic [63:0] rd, input bit poke);
    bit op  = w[31:26] == 6'b011111 && (w[10:1] == 10'b1011010010 || w[10:1] == 10'b1011110010);
    bit isc = w[10:1] == 10'b1011110010;
    start = 1; instr = w; ra_val = a; rb_val = b; hkey = k; isa_v31 = v31;
    @(negedge clk);
    start = 0; ra_val = ~a; rb_val = ~b; hkey = ~k;
    if (!op) begin
      chk(!busy && !done && !hash_req && !illegal && !mem_req, "R1 ignored word", {busy, done, hash_req}, 0);
      return;
    end
    if (!v31) begin
      chk(done && !illegal && !trap && !busy && !hash_req, "R4 old isa nop", {done, illegal, trap, busy, hash_req}, 5'b10000);
      return;
    end
    if (w[20:16] == 0) begin
      chk(done && illegal && !trap && !busy && !hash_req, "R3 ra zero", {done, illegal, trap, busy, hash_req}, 5'b11000);
      return;
    end
    chk(busy && hash_req && !done, "R8 busy/hash_req", {busy, hash_req, done}, 3'b110);
    chk(hash_a == a && hash_b == b && hash_key == k, "R5 operands", hash_a ^ hash_b ^ hash_key, a ^ b ^ k);
    for (int i = 0; i < hl; i++) begin
      if (poke && i == 0) begin
        start = 1; instr = mk(!isc, 5'd0, 5'd3, 6'd1); isa_v31 = 1;
      end
      @(negedge clk);
      start = 0;
      chk(hash_req && !mem_req, "R5 hash hold", hash_req, 1);
    end
    hash_ack = 1; hash_digest = dig;
    @(negedge clk);
    hash_ack = 0; hash_digest = ~dig;
    chk(mem_req && mem_we == !isc && !done, "R6/R7 mem req dir", {mem_req, mem_we}, {1'b1, !isc});
    chk(mem_addr == exp_ea(w, a), "R2 address", mem_addr, exp_ea(w, a));
    if (!isc) chk(mem_wdata == dig, "R6 wdata", mem_wdata, dig);
    for (int i = 0; i < ml; i++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == exp_ea(w, a), "R6 mem hold", mem_addr, exp_ea(w, a));
    end
    mem_ack = 1; mem_rdata = rd;
    @(negedge clk);
    mem_ack = 0; mem_rdata = ~rd;
    chk(done && !busy && !mem_req && !illegal, "R8 done", {done, busy, mem_req, illegal}, 4'b1000);
    chk(trap == (isc && rd != dig), isc ? "R7 trap" : "R6 no trap", trap, isc && rd != dig);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] d, a;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !trap && !hash_req && !mem_req, "R10 reset",
        {busy, done, illegal, trap, hash_req, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R10 after reset", {busy, done, mem_req}, 0);

    // directed corners
    run(mk(0, 5'd4, 5'd5, 6'd0),  64'h1000, 64'h2, 64'hA5, 1, 1, 1, 64'hDEAD_BEEF, 0, 0);           // R2 -512
    @(negedge clk);
    chk(!done, "R8 single done pulse", done, 0);
    run(mk(1, 5'd4, 5'd5, 6'd63), 64'h1000, 64'h2, 64'hA5, 1, 0, 0, 64'h1234, 64'h1234, 0);         // R2 -8, R7 match
    run(mk(1, 5'd7, 5'd1, 6'd33), 64'h8, 64'h9, 64'h3, 1, 2, 3, 64'h55, 64'h54, 0);                 // R7 mismatch
    run(mk(0, 5'd0, 5'd1, 6'd5),  64'h0, 64'h9, 64'h3, 1, 0, 0, 0, 0, 0);                           // R3
    run(mk(1, 5'd0, 5'd1, 6'd5),  64'h0, 64'h9, 64'h3, 0, 0, 0, 0, 0, 0);                           // R4 wins over R3
    run(mk(0, 5'd9, 5'd1, 6'd5),  64'h40, 64'h9, 64'h3, 0, 0, 0, 0, 0, 0);                          // R4
    run(32'h7C00_0214, 64'h40, 64'h9, 64'h3, 1, 0, 0, 0, 0, 0);                                     // R1 other xo
    run({6'b011110, mk(0, 5'd3, 5'd3, 6'd2) & 26'h3FF_FFFF}, 64'h40, 64'h9, 64'h3, 1, 0, 0, 0, 0, 0); // R1 other opc
    run(mk(0, 5'd2, 5'd1, 6'd12), 64'h7000, 64'h9, 64'h3, 1, 3, 1, 64'h77, 64'h0, 1);              // R9 start while busy
    run(mk(1, 5'd2, 5'd1, 6'd12), 64'h7000, 64'h9, 64'h3, 1, 2, 0, 64'h77, 64'h77, 1);             // R9 poke on check

    // constrained random, back-to-back starts
    for (int n = 0; n < 150; n++) begin
      logic [31:0] w;
      int kind = $urandom_range(0, 9);
      d = {$urandom, $urandom};
      a = {$urandom, $urandom};
      w = mk(kind[0], (kind >= 8) ? 5'd0 : 5'($urandom_range(1, 31)), 5'($urandom), 6'($urandom));
      if (kind == 7) w[10:1] = 10'($urandom);
      run(w, a, {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, 7) != 0,
          $urandom_range(0, 3), $urandom_range(0, 3), d,
          $urandom_range(0, 1) ? d : d ^ (64'd1 << $urandom_range(0, 63)), $urandom_range(0, 4) == 0);
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule